// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns eight external pins into one interrupt request line. Each pin has a 2-bit sense mode, a mask bit and a pending flag. Depending on its mode, a pin raises a request on a low level, on any change, on a falling edge or on a rising edge. The two pin groups behave differently. Pins 0 to 3 capture edges without the system clock, so a pulse shorter than a clock period is still caught. Pins 4 to 7 are synchronised first, and edges are found by comparing successive samples.

Software uses a small register port to program the two sense registers and the mask register, and to read and clear the pending flags. The combined request is registered. It is asserted while any unmasked pin is requesting and the global interrupt enable input is high.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, all four registers read 0 and `irq_o` is 0.
- R2: Register addresses are: 0 for the sense fields of pins 0 to 3, 1 for pins 4 to 7, 2 for the mask (bit n for pin n) and 3 for the flags (bit n for pin n). Pin n's 2-bit field sits at bits [2(n mod 4)+1 : 2(n mod 4)] of its sense register. `rdata_o` shows the addressed register one cycle after `addr_i` is presented.
- R3: On pins 4 to 7, mode 01 sets the flag on either edge, mode 10 on a falling edge and mode 11 on a rising edge. The pin is passed through a two-stage synchroniser before the sample comparison.
- R4: On pins 0 to 3, mode 10 sets the flag on a falling edge and mode 11 on a rising edge. Mode 01 is reserved and never sets the flag.
- R5: On pins 0 to 3, a pulse much shorter than one clock period still sets the flag for the selected edge.
- R6: In mode 00, the pin requests for as long as its synchronised level is low. No flag is stored, and flag bit n reads 0.
- R7: A set flag stays set until a 1 is written to its bit at address 3. Writing a 0 to that bit leaves it set.
- R8: A one-cycle pulse on `ack_i[n]` clears flag n.
- R9: `irq_o` is the registered OR of (request and mask) over all pins, ANDed with `gie_i`. It follows a change of `gie_i` or of the mask one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_i | input | 8 | External interrupt pins |
| ack_i | input | 8 | Per-pin acknowledge that clears the flag |
| gie_i | input | 1 | Global interrupt enable |
| addr_i | input | 2 | Register select for read and write |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Combined registered interrupt request |

## Verification
The assertions assume that `rst_i` is high from time zero and that the register port, `ack_i` and `gie_i` are synchronous to `clk_i`. Pins may change at any time. The bench drives every synchronous input at the falling clock edge. Before each trial it clears the mask, rewrites the sense field and wipes the flags, so any event caused by the reconfiguration is removed before the next stimulus. Sub-cycle pulses are applied only to pins 0 to 3, and they are spaced several cycles apart, so that the edge toggles are not cancelled before they are sampled.

// File: rtl/eis_pkg.sv
package eis_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam logic [1:0] REG_SENSE_LO = 2'd0;
  localparam logic [1:0] REG_SENSE_HI = 2'd1;
  localparam logic [1:0] REG_MASK     = 2'd2;
  localparam logic [1:0] REG_FLAG     = 2'd3;
endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/eis_pin_detect.sv
module eis_pin_detect
  import eis_pkg::*;
#(
  parameter bit ASYNC       = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       pin_i,
  input  logic [1:0] mode_i,
  output logic       set_o,
  output logic       low_o
);
  generate
    if (ASYNC) begin : g_async
      // Edge toggles clocked by the pin itself; a change of toggle = one edge
      logic       rise_tgl;
      logic       fall_tgl;
      logic [2:0] sync_w;
      logic [1:0] prev_q;
      logic       rise_evt;
      logic       fall_evt;

      always_ff @(posedge pin_i) rise_tgl <= ~rise_tgl;
      always_ff @(negedge pin_i) fall_tgl <= ~fall_tgl;

      eis_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   ({pin_i, fall_tgl, rise_tgl}),
        .q_o   (sync_w)
      );

      always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= '0;
        else       prev_q <= sync_w[1:0];
      end

      assign rise_evt = sync_w[0] ^ prev_q[0];
      assign fall_evt = sync_w[1] ^ prev_q[1];

      always_comb begin
        case (mode_i)
          SENSE_FALL: set_o = fall_evt;
          SENSE_RISE: set_o = rise_evt;
          default:    set_o = 1'b0;
        endcase
      end

      assign low_o = ~sync_w[2];

      // R4: reserved code never raises an event
      assert_reserved_silent_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == SENSE_ANY) |-> !set_o);
    end else begin : g_sampled
      logic lvl_w;
      logic prev_q;
      logic rise_evt;
      logic fall_evt;

      eis_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (pin_i),
        .q_o   (lvl_w)
      );

      always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= 1'b0;
        else       prev_q <= lvl_w;
      end

      assign rise_evt = lvl_w & ~prev_q;
      assign fall_evt = ~lvl_w & prev_q;

      always_comb begin
        case (mode_i)
          SENSE_ANY:  set_o = rise_evt | fall_evt;
          SENSE_FALL: set_o = fall_evt;
          SENSE_RISE: set_o = rise_evt;
          default:    set_o = 1'b0;
        endcase
      end

      assign low_o = ~lvl_w;
    end
  endgenerate
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eis_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int N_ASYNC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [DATA_W-1:0] pin_i,
  input  logic [DATA_W-1:0] ack_i,
  input  logic              gie_i,
  input  logic [1:0]        addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int NPINS   = DATA_W;
  localparam int SENSE_W = 2 * NPINS;

  logic [SENSE_W-1:0] sense_q;
  logic [NPINS-1:0]   mask_q;
  logic [NPINS-1:0]   flag_q;
  logic [NPINS-1:0]   flag_d;
  logic [NPINS-1:0]   set_w;
  logic [NPINS-1:0]   low_w;
  logic [NPINS-1:0]   clr_w;
  logic [NPINS-1:0]   req_w;
  logic [NPINS-1:0]   lvl_mode_w;
  logic [NPINS-1:0]   w1c_w;

  // Configuration registers
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sense_q <= '0;
      mask_q  <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        REG_SENSE_LO: sense_q[DATA_W-1:0]       <= wdata_i;
        REG_SENSE_HI: sense_q[SENSE_W-1:DATA_W] <= wdata_i;
        REG_MASK:     mask_q                    <= wdata_i;
        default: ;
      endcase
    end
  end

  assign w1c_w = (wr_en_i && addr_i == REG_FLAG) ? wdata_i : '0;

  genvar n;
  generate
    for (n = 0; n < NPINS; n++) begin : g_pin
      eis_pin_detect #(
        .ASYNC       (n < N_ASYNC),
        .SYNC_STAGES (SYNC_STAGES)
      ) u_det (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .pin_i  (pin_i[n]),
        .mode_i (sense_q[2*n +: 2]),
        .set_o  (set_w[n]),
        .low_o  (low_w[n])
      );

      assign lvl_mode_w[n] = (sense_q[2*n +: 2] == SENSE_LOW);
      assign clr_w[n]      = ack_i[n] | w1c_w[n];
      // new event wins over a clear in the same cycle
      assign flag_d[n]     = lvl_mode_w[n] ? 1'b0 :
                             set_w[n]      ? 1'b1 :
                             clr_w[n]      ? 1'b0 : flag_q[n];
      assign req_w[n]      = lvl_mode_w[n] ? low_w[n] : flag_q[n];

      // R3: an event is latched in the following cycle
      assert_event_latched_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(set_w[n]) |-> flag_q[n]);
      // R6: level mode keeps no stored flag
      assert_level_no_flag_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(sense_q[2*n +: 2]) == SENSE_LOW) |-> !flag_q[n]);
      // R7: a flag is held until cleared
      assert_flag_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(flag_q[n]) && !$past(clr_w[n]) && ($past(sense_q[2*n +: 2]) != SENSE_LOW))
        |-> flag_q[n]);
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      flag_q  <= '0;
      irq_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      flag_q <= flag_d;
      irq_o  <= gie_i & |(req_w & mask_q);
      case (addr_i)
        REG_SENSE_LO: rdata_o <= sense_q[DATA_W-1:0];
        REG_SENSE_HI: rdata_o <= sense_q[SENSE_W-1:DATA_W];
        REG_MASK:     rdata_o <= mask_q;
        default:      rdata_o <= flag_q;
      endcase
    end
  end

  // R9: no request leaves the block without the global enable
  assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(gie_i) |-> !irq_o);
  // R9: no request with an all-zero mask
  assert_irq_masked_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(mask_q) == '0) |-> !irq_o);
endmodule

// File: tb/sim_ext_irq_sense.sv
module sim_ext_irq_sense;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pins = 8'hFF;
  logic [7:0] ack = 8'h00;
  logic       gie = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int vec  = 0;
  int miss = 0;

  always #5 clk = ~clk;

  ext_irq_sense u0 (
    .clk_i   (clk),
    .rst_i   (rst),
    .pin_i   (pins),
    .ack_i   (ack),
    .gie_i   (gie),
    .addr_i  (addr),
    .wr_en_i (wr_en),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vec++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  initial begin
    #(200000 * 10);
    miss++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] fld;
    logic       ef;
    logic       er;
    string      etag;

    idle(4);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk(irq, 0, "R1 irq after reset");
    for (int a = 0; a < 4; a++) begin
      reg_read(a[1:0], rd);
      chk(rd, 0, "R1 register after reset");
    end

    // R2 read-back
    reg_write(0, 8'hE4); reg_read(0, rd); chk(rd, 8'hE4, "R2 sense lo readback");
    reg_write(1, 8'h1B); reg_read(1, rd); chk(rd, 8'h1B, "R2 sense hi readback");
    reg_write(2, 8'hA5); reg_read(2, rd); chk(rd, 8'hA5, "R2 mask readback");
    reg_write(2, 8'h00);

    // Sweep every pin through every mode
    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < 4; m++) begin
        fld = 8'(m << (2 * (p % 4)));
        etag = (p < 4) ? "R4 async edge" : "R3 sampled edge";
        if (m == 0) etag = "R6 level no flag";
        reg_write(2, 8'h00);
        reg_write(0, (p < 4) ? fld : 8'h00);
        reg_write(1, (p >= 4) ? fld : 8'h00);
        pins = 8'hFF;
        idle(6);
        reg_write(3, 8'hFF);
        reg_write(2, 8'(1 << p));
        gie = 1'b1;
        idle(3);
        chk(irq, 0, "R9 idle request");
        ef = (m == 2) || (m == 1 && p >= 4);
        er = (m == 3) || (m == 1 && p >= 4);
        // falling edge
        pins[p] = 1'b0;
        idle(6);
        chk(irq, ef | (m == 0), (m == 0) ? "R6 level low request" : "R9 edge request");
        reg_read(3, rd);
        chk(rd, ef ? 8'(1 << p) : 8'h00, etag);
        reg_write(3, 8'(1 << p));
        idle(2);
        reg_read(3, rd);
        chk(rd, 0, "R7 write-one clear");
        chk(irq, (m == 0), "R9 request after clear");
        // rising edge
        pins[p] = 1'b1;
        idle(6);
        chk(irq, er, (m == 0) ? "R6 level released" : "R9 edge request");
        reg_read(3, rd);
        chk(rd, er ? 8'(1 << p) : 8'h00, etag);
        reg_write(3, 8'hFF);
      end
    end

    // R7 / R8 on pin 5, falling mode
    gie = 1'b0;
    reg_write(2, 8'h00);
    reg_write(0, 8'h00);
    reg_write(1, 8'h08);
    pins = 8'hFF;
    idle(6);
    reg_write(3, 8'hFF);
    pins[5] = 1'b0;
    idle(6);
    reg_write(3, 8'h01);
    idle(2);
    reg_read(3, rd);
    chk(rd, 8'h20, "R7 flag held after zero write");
    @(negedge clk); ack = 8'h20;
    @(negedge clk); ack = 8'h00;
    idle(1);
    reg_read(3, rd);
    chk(rd, 8'h00, "R8 ack clears flag");

    // R9 global enable and mask gating
    pins[5] = 1'b1; idle(4);
    pins[5] = 1'b0; idle(6);
    reg_write(2, 8'h20);
    idle(2);
    chk(irq, 0, "R9 gie low blocks request");
    reg_read(3, rd);
    chk(rd, 8'h20, "R9 flag set while gie low");
    @(negedge clk); gie = 1'b1;
    @(negedge clk);
    chk(irq, 1, "R9 one cycle after gie rise");
    reg_write(2, 8'h00);
    @(negedge clk);
    chk(irq, 0, "R9 one cycle after mask clear");

    // R5 sub-cycle pulses on pin 2
    gie = 1'b0;
    pins = 8'hFF;
    reg_write(1, 8'h00);
    reg_write(0, 8'h30);
    idle(6);
    reg_write(3, 8'hFF);
    @(negedge clk);
    #2 pins[2] = 1'b0;
    #3 pins[2] = 1'b1;
    idle(6);
    reg_read(3, rd);
    chk(rd, 8'h04, "R5 short pulse rising capture");
    reg_write(0, 8'h20);
    idle(6);
    reg_write(3, 8'hFF);
    @(negedge clk);
    #2 pins[2] = 1'b0;
    #3 pins[2] = 1'b1;
    idle(6);
    reg_read(3, rd);
    chk(rd, 8'h04, "R5 short pulse falling capture");

    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule